// File: doc/BRIEF.md
# Segmented Fetch Address Unit

This block is the addressing half of a bus unit for a processor with 16-bit segment and offset values and a one-megabyte physical space. It keeps four segment base registers (code, stack, data, extra) and a 16-bit fetch offset. It forms a 20-bit physical address for whichever access wins the cycle. Each cycle carries at most one access. An access requested by the execution side (a stack or a data access) wins. Otherwise, when the prefetch queue has room, an instruction prefetch goes out from code:fetch-offset.

A level counter tracks the bytes that have been prefetched but not yet consumed by the execution side. The block always presents a corrected pointer: the fetch offset minus that level. This gives the offset of the next instruction to execute, which is the value to push when the pointer is saved. A control transfer (a jump, or a restore from the stack) loads a new code segment and offset and empties the queue. Prefetch resumes from the new location on the following cycle.

Top module: `seg_fetch_unit`

## Requirements
- R1: On reset the code segment takes `RESET_CS` (default 16'hFFFF). The stack, data and extra segments take zero. The fetch offset takes `RESET_IP` (default 0) and the queue level is 0, so the first prefetch address is 20'hFFFF0.
- R2: A physical address equals the segment shifted left by four plus the zero-extended offset, modulo 2^20 (a carry out of bit 19 is lost). `bus_addr` is 0 whenever `bus_kind` is idle.
- R3: `bus_kind` encodes 2'b00 idle, 2'b01 prefetch, 2'b10 stack, 2'b11 data. A prefetch uses code:fetch-offset. Each prefetch advances the fetch offset by one (modulo 2^16) and raises the level by one.
- R4: A stack access (`mem_stack`=1) uses the stack segment. A data access uses the data segment, or the extra segment when `mem_alt`=1. In both cases the offset is `mem_off`.
- R5: A request on `mem_req` wins the cycle. No prefetch is issued, and the fetch offset and level do not advance.
- R6: The level never exceeds `DEPTH` (default 6). At `DEPTH` no prefetch is issued, and `bus_kind` is idle unless a request is present.
- R7: `q_consume` lowers the level by one. A consume while the level is 0 is ignored. A consume in the same cycle as a prefetch leaves the level unchanged.
- R8: `saved_ip` equals fetch offset minus level, modulo 2^16, at all times.
- R9: `xfer_en` loads the code segment and fetch offset from `xfer_seg`/`xfer_off` and clears the level. It takes precedence over a consume in that cycle and issues no prefetch. The next prefetch uses the new address.
- R10: `seg_wr_sel` encodes 0 code, 1 stack, 2 data, 3 extra. A write to 1..3 takes effect from the next cycle. A write that selects 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment register select for the write |
| seg_wr_data | input | 16 | Segment write value |
| xfer_en | input | 1 | Control transfer: reload code segment and offset, flush queue |
| xfer_seg | input | 16 | New code segment |
| xfer_off | input | 16 | New fetch offset |
| mem_req | input | 1 | Execution-side access request this cycle |
| mem_stack | input | 1 | 1 = stack access, 0 = data access |
| mem_alt | input | 1 | Data access uses the extra segment |
| mem_off | input | 16 | Offset of the requested access |
| q_consume | input | 1 | Execution side takes one byte from the queue |
| bus_kind | output | 2 | Access kind this cycle |
| bus_addr | output | 20 | Physical address of the access |
| saved_ip | output | 16 | Offset of the next instruction to execute |
| q_level | output | CNT_W | Bytes prefetched and not yet consumed |

## Verification
The hardest state to reach is a full queue while a consume and a transfer are both pending. It needs several uninterrupted prefetches with no consumes after a transfer, and the corrected pointer must then wrap below zero. The stimulus table places a transfer to offset 16'hFFFE and lets the fetch offset roll over to zero while the level is still positive. It then fills the queue to the limit, consumes once at the limit, and transfers again. The last transfer goes to a code segment of 16'hFFFF, so the following prefetch address carries out of bit 19.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  typedef enum logic [1:0] {
    BK_IDLE  = 2'b00,
    BK_FETCH = 2'b01,
    BK_STACK = 2'b10,
    BK_DATA  = 2'b11
  } bus_kind_e;

  typedef enum logic [1:0] {
    SG_CODE  = 2'd0,
    SG_STACK = 2'd1,
    SG_DATA  = 2'd2,
    SG_EXTRA = 2'd3
  } seg_sel_e;
endpackage

// File: rtl/sfu_seg_file.sv
module sfu_seg_file #(
  parameter int SEG_W = 16,
  parameter int NSEG = 4,
  parameter logic [SEG_W-1:0] RESET_CS = '1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [1:0]                wr_sel,
  input  logic [SEG_W-1:0]          wr_data,
  input  logic                      xfer_en,
  input  logic [SEG_W-1:0]          xfer_seg,
  output logic [NSEG-1:0][SEG_W-1:0] seg_q
);
  logic [NSEG-1:0]            seg_en;
  logic [NSEG-1:0][SEG_W-1:0] seg_d;

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    if (i == int'(sfu_pkg::SG_CODE)) begin : g_code
      // code base changes only through a control transfer
      always_comb begin
        seg_en[i] = xfer_en;
        seg_d[i]  = xfer_seg;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         seg_q[i] <= RESET_CS;
        else if (seg_en[i]) seg_q[i] <= seg_d[i];
      end
    end else begin : g_plain
      always_comb begin
        seg_en[i] = wr_en && (wr_sel == 2'(i));
        seg_d[i]  = wr_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         seg_q[i] <= '0;
        else if (seg_en[i]) seg_q[i] <= seg_d[i];
      end
    end
  end
endmodule

// File: rtl/sfu_fetch_ctrl.sv
module sfu_fetch_ctrl #(
  parameter int OFF_W = 16,
  parameter int DEPTH = 6,
  parameter int CNT_W = 3,
  parameter logic [OFF_W-1:0] RESET_IP = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_en,
  input  logic [OFF_W-1:0] xfer_off,
  input  logic             mem_req,
  input  logic             consume,
  output logic [OFF_W-1:0] fetch_ip,
  output logic [CNT_W-1:0] level,
  output logic             pf_issue,
  output logic [OFF_W-1:0] saved_ip
);
  localparam logic [CNT_W-1:0] LVL_FULL = CNT_W'(DEPTH);

  logic [OFF_W-1:0] ip_q, ip_d;
  logic [CNT_W-1:0] lvl_q, lvl_d;
  logic             ip_en, lvl_en, full, take;

  always_comb begin
    full     = (lvl_q == LVL_FULL);
    pf_issue = !xfer_en && !mem_req && !full;
    take     = consume && (lvl_q != '0);
  end

  // next-state: fetch offset
  always_comb begin
    ip_en = xfer_en || pf_issue;
    ip_d  = xfer_en ? xfer_off : ip_q + OFF_W'(1);
  end

  // next-state: queue level
  always_comb begin
    lvl_en = xfer_en || (pf_issue != take);
    lvl_d  = lvl_q;
    if (xfer_en)       lvl_d = '0;
    else if (pf_issue) lvl_d = lvl_q + CNT_W'(1);
    else if (take)     lvl_d = lvl_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ip_q <= RESET_IP;
    else if (ip_en) ip_q <= ip_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '0;
    else if (lvl_en) lvl_q <= lvl_d;
  end

  always_comb begin
    fetch_ip = ip_q;
    level    = lvl_q;
    saved_ip = ip_q - OFF_W'(lvl_q);
  end
endmodule

// File: rtl/sfu_addr_gen.sv
module sfu_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int PA_W  = 20
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  pa
);
  localparam int SHIFT = PA_W - SEG_W;

  logic [PA_W-1:0] seg_x, off_x;

  always_comb begin
    seg_x = {seg, {SHIFT{1'b0}}};
    off_x = PA_W'(off);
    pa    = seg_x + off_x;
  end
endmodule

// File: rtl/seg_fetch_unit.sv
module seg_fetch_unit #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int PA_W  = 20,
  parameter int DEPTH = 6,
  parameter logic [SEG_W-1:0] RESET_CS = '1,
  parameter logic [OFF_W-1:0] RESET_IP = '0,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_wr_en,
  input  logic [1:0]       seg_wr_sel,
  input  logic [SEG_W-1:0] seg_wr_data,
  input  logic             xfer_en,
  input  logic [SEG_W-1:0] xfer_seg,
  input  logic [OFF_W-1:0] xfer_off,
  input  logic             mem_req,
  input  logic             mem_stack,
  input  logic             mem_alt,
  input  logic [OFF_W-1:0] mem_off,
  input  logic             q_consume,
  output logic [1:0]       bus_kind,
  output logic [PA_W-1:0]  bus_addr,
  output logic [OFF_W-1:0] saved_ip,
  output logic [CNT_W-1:0] q_level
);
  import sfu_pkg::*;

  localparam int NSEG = 4;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [NSEG-1:0][SEG_W-1:0] seg_q;
  logic [OFF_W-1:0]           fetch_ip;
  logic                       pf_issue;
  logic [SEG_W-1:0]           mem_seg;
  logic [PA_W-1:0]            pa_fetch, pa_mem;
  bus_kind_e                  kind;

  sfu_seg_file #(
    .SEG_W(SEG_W), .NSEG(NSEG), .RESET_CS(RESET_CS)
  ) u_segs (
    .clk(clk), .rst_n(rst_n_s),
    .wr_en(seg_wr_en), .wr_sel(seg_wr_sel), .wr_data(seg_wr_data),
    .xfer_en(xfer_en), .xfer_seg(xfer_seg),
    .seg_q(seg_q)
  );

  sfu_fetch_ctrl #(
    .OFF_W(OFF_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .RESET_IP(RESET_IP)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n_s),
    .xfer_en(xfer_en), .xfer_off(xfer_off),
    .mem_req(mem_req), .consume(q_consume),
    .fetch_ip(fetch_ip), .level(q_level),
    .pf_issue(pf_issue), .saved_ip(saved_ip)
  );

  always_comb begin
    if (mem_stack)    mem_seg = seg_q[SG_STACK];
    else if (mem_alt) mem_seg = seg_q[SG_EXTRA];
    else              mem_seg = seg_q[SG_DATA];
  end

  sfu_addr_gen #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_pa_fetch (
    .seg(seg_q[SG_CODE]), .off(fetch_ip), .pa(pa_fetch)
  );

  sfu_addr_gen #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_pa_mem (
    .seg(mem_seg), .off(mem_off), .pa(pa_mem)
  );

  always_comb begin
    kind     = BK_IDLE;
    bus_addr = '0;
    if (mem_req) begin
      kind     = mem_stack ? BK_STACK : BK_DATA;
      bus_addr = pa_mem;
    end else if (pf_issue) begin
      kind     = BK_FETCH;
      bus_addr = pa_fetch;
    end
    bus_kind = kind;
  end
endmodule

// File: rtl/seg_fetch_unit_chk.sv
module seg_fetch_unit_chk #(
  parameter int OFF_W = 16,
  parameter int PA_W  = 20,
  parameter int DEPTH = 6,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xfer_en,
  input logic             mem_req,
  input logic             q_consume,
  input logic [1:0]       bus_kind,
  input logic [PA_W-1:0]  bus_addr,
  input logic [OFF_W-1:0] saved_ip,
  input logic [CNT_W-1:0] q_level
);
  import sfu_pkg::*;

  AST_LEVEL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_level) <= DEPTH);  // R6
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(q_level) == DEPTH) |-> (bus_kind != BK_FETCH));  // R6
  AST_REQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (bus_kind == BK_STACK || bus_kind == BK_DATA));  // R5
  AST_XFER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_en |=> (q_level == '0));  // R9
  AST_XFER_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && !mem_req) |-> (bus_kind == BK_IDLE));  // R9
  AST_FETCH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_kind == BK_FETCH && !q_consume) |=> (int'(q_level) == int'($past(q_level)) + 1));  // R3
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_kind == BK_IDLE) |-> (bus_addr == '0));  // R2
  AST_SAVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_kind != BK_FETCH && !xfer_en && !q_consume) |=> $stable(saved_ip));  // R8
  AST_EMPTY_CONSUME: assert property (@(posedge clk) disable iff (!rst_n)
    (q_level == '0 && q_consume && !xfer_en && bus_kind != BK_FETCH) |=> (q_level == '0));  // R7
endmodule

bind seg_fetch_unit seg_fetch_unit_chk #(
  .OFF_W(OFF_W), .PA_W(PA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n_s), .xfer_en(xfer_en), .mem_req(mem_req),
  .q_consume(q_consume), .bus_kind(bus_kind), .bus_addr(bus_addr),
  .saved_ip(saved_ip), .q_level(q_level)
);

// File: tb/seg_fetch_unit_test.sv
module seg_fetch_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        seg_wr_en;
  logic [1:0]  seg_wr_sel;
  logic [15:0] seg_wr_data;
  logic        xfer_en;
  logic [15:0] xfer_seg, xfer_off;
  logic        mem_req, mem_stack, mem_alt;
  logic [15:0] mem_off;
  logic        q_consume;
  logic [1:0]  bus_kind;
  logic [19:0] bus_addr;
  logic [15:0] saved_ip;
  logic [2:0]  q_level;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_fetch_unit uut (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
    .xfer_en(xfer_en), .xfer_seg(xfer_seg), .xfer_off(xfer_off),
    .mem_req(mem_req), .mem_stack(mem_stack), .mem_alt(mem_alt), .mem_off(mem_off),
    .q_consume(q_consume),
    .bus_kind(bus_kind), .bus_addr(bus_addr), .saved_ip(saved_ip), .q_level(q_level)
  );

  typedef struct packed {
    logic        swe;
    logic [1:0]  ssel;
    logic [15:0] sdat;
    logic        jmp;
    logic [15:0] jseg;
    logic [15:0] joff;
    logic        req;
    logic        stk;
    logic        alt;
    logic [15:0] off;
    logic        cons;
    logic [1:0]  ekind;
    logic [19:0] eaddr;
    logic [15:0] esave;
    logic [2:0]  elvl;
    logic [3:0]  rq;
  } vec_t;

  // inputs for one cycle, then the outputs expected before that cycle's edge
  localparam vec_t VEC [NVEC] = '{
    // R10 stack write; R1 first prefetch at FFFF0
    '{1'b1, 2'd1, 16'h1234, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b01, 20'hFFFF0, 16'h0000, 3'd0, 4'd1},
    // R3 second prefetch, data write
    '{1'b1, 2'd2, 16'h2000, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b01, 20'hFFFF1, 16'h0000, 3'd1, 4'd3},
    // R4 R5 stack access wins, extra write
    '{1'b1, 2'd3, 16'h3000, 1'b0, 16'h0, 16'h0, 1'b1, 1'b1, 1'b0, 16'h0010, 1'b0, 2'b10, 20'h12350, 16'h0000, 3'd2, 4'd4},
    // R2 data access, offset FFFF
    '{1'b0, 2'd0, 16'h0, 1'b0, 16'h0, 16'h0, 1'b1, 1'b0, 1'b0, 16'hFFFF, 1'b0, 2'b11, 20'h2FFFF, 16'h0000, 3'd2, 4'd2},
    // R4 data access via extra segment
    '{1'b0, 2'd0, 16'h0, 1'b0, 16'h0, 16'h0, 1'b1, 1'b0, 1'b1, 16'h0005, 1'b0, 2'b11, 20'h30005, 16'h0000, 3'd2, 4'd4},
    // R10 code write ignored; R7 consume with prefetch
    '{1'b1, 2'd0, 16'hABCD, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b1, 2'b01, 20'hFFFF2, 16'h0000, 3'd2, 4'd10},
    // R8 corrected pointer
    '{1'b0, 2'd0, 16'h0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b01, 20'hFFFF3, 16'h0001, 3'd2, 4'd8},
    // R9 transfer with consume: no prefetch
    '{1'b0, 2'd0, 16'h0, 1'b1, 16'h0100, 16'hFFFE, 1'b0, 1'b0, 1'b0, 16'h0, 1'b1, 2'b00, 20'h00000, 16'h0001, 3'd3, 4'd9},
    // R9 prefetch from new address, level 0
    '{1'b0, 2'd0, 16'h0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b01, 20'h10FFE, 16'hFFFE, 3'd0, 4'd9},
    // R3
    '{1'b0, 2'd0, 16'h0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b01, 20'h10FFF, 16'hFFFE, 3'd1, 4'd3},
    // R8 offset wrapped, pointer below zero
    '{1'b0, 2'd0, 16'h0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b01, 20'h01000, 16'hFFFE, 3'd2, 4'd8},
    '{1'b0, 2'd0, 16'h0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b01, 20'h01001, 16'hFFFE, 3'd3, 4'd3},
    '{1'b0, 2'd0, 16'h0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b01, 20'h01002, 16'hFFFE, 3'd4, 4'd3},
    '{1'b0, 2'd0, 16'h0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b01, 20'h01003, 16'hFFFE, 3'd5, 4'd3},
    // R6 full: idle
    '{1'b0, 2'd0, 16'h0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b00, 20'h00000, 16'hFFFE, 3'd6, 4'd6},
    // R6 consume while full: still stalled this cycle
    '{1'b0, 2'd0, 16'h0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b1, 2'b00, 20'h00000, 16'hFFFE, 3'd6, 4'd6},
    // R7 level dropped, prefetch resumes
    '{1'b0, 2'd0, 16'h0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b01, 20'h01004, 16'hFFFF, 3'd5, 4'd7},
    // R9 transfer to FFFF:0010 while full
    '{1'b0, 2'd0, 16'h0, 1'b1, 16'hFFFF, 16'h0010, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b00, 20'h00000, 16'hFFFF, 3'd6, 4'd9},
    // R2 carry out of bit 19 dropped; R7 consume at empty
    '{1'b0, 2'd0, 16'h0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b1, 2'b01, 20'h00000, 16'h0010, 3'd0, 4'd7},
    // R7 empty consume left level at 0, now 1
    '{1'b0, 2'd0, 16'h0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 2'b01, 20'h00001, 16'h0010, 3'd1, 4'd7}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    seg_wr_en = 1'b0; seg_wr_sel = 2'd0; seg_wr_data = 16'h0;
    xfer_en = 1'b0; xfer_seg = 16'h0; xfer_off = 16'h0;
    mem_req = 1'b0; mem_stack = 1'b0; mem_alt = 1'b0; mem_off = 16'h0;
    q_consume = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R1 reset state
    check("R1", "reset kind", 32'(bus_kind), 32'h1);
    check("R1", "reset addr", 32'(bus_addr), 32'hFFFF0);
    check("R1", "reset saved", 32'(saved_ip), 32'h0);
    check("R1", "reset level", 32'(q_level), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      seg_wr_en = VEC[i].swe; seg_wr_sel = VEC[i].ssel; seg_wr_data = VEC[i].sdat;
      xfer_en = VEC[i].jmp; xfer_seg = VEC[i].jseg; xfer_off = VEC[i].joff;
      mem_req = VEC[i].req; mem_stack = VEC[i].stk; mem_alt = VEC[i].alt;
      mem_off = VEC[i].off; q_consume = VEC[i].cons;
      #1;
      check($sformatf("R%0d v%0d", VEC[i].rq, i), "kind", 32'(bus_kind), 32'(VEC[i].ekind));
      check($sformatf("R%0d v%0d", VEC[i].rq, i), "addr", 32'(bus_addr), 32'(VEC[i].eaddr));
      check($sformatf("R%0d v%0d", VEC[i].rq, i), "saved", 32'(saved_ip), 32'(VEC[i].esave));
      check($sformatf("R%0d v%0d", VEC[i].rq, i), "level", 32'(q_level), 32'(VEC[i].elvl));
    end

    // R5 request during prefetch: offset and level held across the edge
    @(negedge clk);
    idle_inputs();
    mem_req = 1'b1; mem_stack = 1'b1; mem_off = 16'h0002;
    @(negedge clk);
    #1;
    check("R5", "level held", 32'(q_level), 32'd2);
    check("R4", "stack addr", 32'(bus_addr), 32'h12342);

    // R1 asynchronous reset mid-run clears segments and queue
    rst_n = 1'b0;
    #1;
    check("R1", "stack seg cleared", 32'(bus_addr), 32'h00002);
    check("R1", "level cleared", 32'(q_level), 32'h0);
    mem_req = 1'b0;
    #1;
    check("R1", "fetch addr after reset", 32'(bus_addr), 32'hFFFF0);
    check("R1", "saved after reset", 32'(saved_ip), 32'h0);
    idle_inputs();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule